// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer

This block fetches a run of bytes from a serial EEPROM whose bus is opened and closed by two access lines instead of a single select. A one-cycle start pulse captures a 16-bit byte offset and a byte count. The block then opens the bus in two ordered steps, shifts out a read command followed by the offset, and clocks in the requested number of bytes. Each completed byte appears on `rx_byte` together with a one-cycle `byte_valid` strobe. Finally the bus is closed in two ordered steps and `done` pulses.

Every change on the serial lines is a discrete step that is held for `PHASE_CLKS` system clocks, so the serial clock runs far below the system clock. An output bit is a set-data, raise-clock, lower-clock sequence. An input bit is a raise-clock, sample, lower-clock sequence.

Top module: `eeprom_read_seq`

## Requirements
- R1: After synchronous reset, `rom_acc_hi`=0, `rom_acc_lo`=1, `rom_clk`=0, `rom_dout`=0, and `busy`, `done` and `byte_valid` are all 0.
- R2: Opening the bus raises `rom_acc_hi` while `rom_acc_lo` is 1. `rom_acc_lo` then falls while `rom_acc_hi` is 1, no sooner than `PHASE_CLKS` cycles later.
- R3: Closing the bus raises `rom_acc_lo` while `rom_acc_hi` is 1. `rom_acc_hi` then falls while `rom_acc_lo` is 1, no sooner than `PHASE_CLKS` cycles later.
- R4: The first 24 bits sampled on rising `rom_clk` edges are the command 0x03, then offset bits 15..8, then offset bits 7..0, each byte MSB first.
- R5: `rom_dout` never changes while `rom_clk` is 1, and it is never different from its value in the cycle before `rom_clk` rises.
- R6: After the header, `rd_count` bytes are read. Each one is built MSB first from `rom_din` sampled while `rom_clk` is high, and is presented on `rx_byte` with a one-cycle `byte_valid`, only while `busy` is 1.
- R7: Every high interval of `rom_clk` lasts exactly `PHASE_CLKS` system clocks.
- R8: A `rd_count` of zero still runs the open, header and close steps and pulses `done`, with no `byte_valid`.
- R9: `busy` is 1 from the cycle after an accepted start until `done`. A start pulse while `busy` is 1 is ignored. A start pulse in the cycle where `done` is 1 is accepted.
- R10: `done` is a single-cycle pulse, issued after `rom_acc_hi` has returned to 0, in the cycle where `busy` drops.
- R11: `rom_clk` is 1 only while the bus is open (`rom_acc_hi`=1 and `rom_acc_lo`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a read |
| rd_offset | input | 16 | Byte offset of the first byte |
| rd_count | input | COUNT_W | Number of bytes to read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| byte_valid | output | 1 | One-cycle strobe for `rx_byte` |
| rx_byte | output | 8 | Last received byte |
| rom_acc_hi | output | 1 | Access line, idle low |
| rom_acc_lo | output | 1 | Access line, idle high |
| rom_clk | output | 1 | Serial clock |
| rom_dout | output | 1 | Serial data to the EEPROM |
| rom_din | input | 1 | Serial data from the EEPROM |

## Verification
Two events can land in the same cycle. One is the end of a transaction, where `done` rises and `busy` drops. The other is the acceptance of a new start. The bench raises `start` in exactly the cycle where it sees `done`. It then requires that `busy` is 1 one cycle later and that a second, complete transaction follows with its own offset and data. A separate test pulses `start` in the middle of a transfer. That test requires exactly one bus opening, one `done` pulse and the original header and byte stream.

// File: rtl/eers_pkg.sv
package eers_pkg;

    localparam logic [7:0] READ_CMD = 8'h03;
    localparam int HDR_BITS = 24;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPEN_A,
        ST_OPEN_B,
        ST_TX_SET,
        ST_TX_HIGH,
        ST_TX_LOW,
        ST_RX_HIGH,
        ST_RX_LOW,
        ST_CLOSE_A,
        ST_CLOSE_B
    } seq_state_e;

    typedef struct packed {
        logic acc_hi;
        logic acc_lo;
        logic sclk;
    } bus_lines_t;

    function automatic bus_lines_t lines_of(seq_state_e s);
        bus_lines_t l;
        l.sclk = (s == ST_TX_HIGH) || (s == ST_RX_HIGH);
        case (s)
            ST_IDLE:    begin l.acc_hi = 1'b0; l.acc_lo = 1'b1; end
            ST_OPEN_A:  begin l.acc_hi = 1'b1; l.acc_lo = 1'b1; end
            ST_CLOSE_A: begin l.acc_hi = 1'b1; l.acc_lo = 1'b1; end
            ST_CLOSE_B: begin l.acc_hi = 1'b0; l.acc_lo = 1'b1; end
            default:    begin l.acc_hi = 1'b1; l.acc_lo = 1'b0; end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/eers_phase_timer.sv
module eers_phase_timer #(
    parameter int PHASE_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(PHASE_CLKS + 1);
    localparam logic [CW-1:0] MAXV = CW'(PHASE_CLKS - 1);

    logic [CW-1:0] cnt;

    assign last = run && (cnt == MAXV);

    always_ff @(posedge clk) begin
        if (rst || !run || last) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= MAXV);
endmodule

// File: rtl/eers_shift.sv
module eers_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[W-2:0], shift_in};
    end
endmodule

// File: rtl/eeprom_read_seq.sv
module eeprom_read_seq
    import eers_pkg::*;
#(
    parameter int PHASE_CLKS = 4,
    parameter int COUNT_W    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [15:0]        rd_offset,
    input  logic [COUNT_W-1:0] rd_count,
    output logic               busy,
    output logic               done,
    output logic               byte_valid,
    output logic [7:0]         rx_byte,
    output logic               rom_acc_hi,
    output logic               rom_acc_lo,
    output logic               rom_clk,
    output logic               rom_dout,
    input  logic               rom_din
);
    localparam int HB_W = $clog2(HDR_BITS);
    localparam logic [HB_W-1:0] HB_LAST = HB_W'(HDR_BITS - 1);

    seq_state_e state;
    bus_lines_t lines;
    logic tick;
    logic accept;
    logic [HB_W-1:0] tx_bit;
    logic [2:0] rx_bit;
    logic [COUNT_W-1:0] left;
    logic [HDR_BITS-1:0] tx_q;
    logic [7:0] rx_q;
    logic tx_shift, rx_shift;

    assign accept = (state == ST_IDLE) && start;
    assign busy   = (state != ST_IDLE);
    assign lines  = lines_of(state);
    assign rom_acc_hi = lines.acc_hi;
    assign rom_acc_lo = lines.acc_lo;
    assign rom_clk    = lines.sclk;
    assign rom_dout   = tx_q[HDR_BITS-1];

    // The last header bit is not shifted away, so the data line holds still while reading.
    assign tx_shift = tick && (state == ST_TX_LOW) && (tx_bit != HB_LAST);
    assign rx_shift = tick && (state == ST_RX_HIGH);

    eers_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) i_timer (
        .clk(clk), .rst(rst), .run(busy), .last(tick)
    );

    eers_shift #(.W(HDR_BITS)) i_tx (
        .clk(clk), .rst(rst), .load(accept),
        .load_val({READ_CMD, rd_offset}),
        .shift(tx_shift), .shift_in(1'b0), .q(tx_q)
    );

    eers_shift #(.W(8)) i_rx (
        .clk(clk), .rst(rst), .load(1'b0), .load_val(8'h00),
        .shift(rx_shift), .shift_in(rom_din), .q(rx_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            tx_bit     <= '0;
            rx_bit     <= '0;
            left       <= '0;
            done       <= 1'b0;
            byte_valid <= 1'b0;
            rx_byte    <= 8'h00;
        end else begin
            done       <= 1'b0;
            byte_valid <= 1'b0;
            if (accept) begin
                state  <= ST_OPEN_A;
                left   <= rd_count;
                tx_bit <= '0;
            end else if (tick) begin
                case (state)
                    ST_OPEN_A:  state <= ST_OPEN_B;
                    ST_OPEN_B:  state <= ST_TX_SET;
                    ST_TX_SET:  state <= ST_TX_HIGH;
                    ST_TX_HIGH: state <= ST_TX_LOW;
                    ST_TX_LOW: begin
                        if (tx_bit == HB_LAST) begin
                            rx_bit <= '0;
                            state  <= (left == '0) ? ST_CLOSE_A : ST_RX_HIGH;
                        end else begin
                            tx_bit <= tx_bit + 1'b1;
                            state  <= ST_TX_SET;
                        end
                    end
                    ST_RX_HIGH: state <= ST_RX_LOW;
                    ST_RX_LOW: begin
                        rx_bit <= rx_bit + 1'b1;
                        if (rx_bit == 3'd7) begin
                            byte_valid <= 1'b1;
                            rx_byte    <= rx_q;
                            left       <= left - 1'b1;
                            state      <= (left == COUNT_W'(1)) ? ST_CLOSE_A : ST_RX_HIGH;
                        end else begin
                            state <= ST_RX_HIGH;
                        end
                    end
                    ST_CLOSE_A: state <= ST_CLOSE_B;
                    ST_CLOSE_B: begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    p_sclk_gated_r11: assert property (@(posedge clk) disable iff (rst)
        rom_clk |-> (rom_acc_hi && !rom_acc_lo));
    p_dout_hold_r5: assert property (@(posedge clk) disable iff (rst)
        rom_clk |-> $stable(rom_dout));
    p_open_order_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rom_acc_lo) |-> (rom_acc_hi && $past(rom_acc_hi)));
    p_close_order_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rom_acc_hi) |-> (rom_acc_lo && $past(rom_acc_lo)));
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !rom_acc_hi));
    p_valid_busy_r6: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> busy);
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> busy);
endmodule

// File: tb/test_eeprom_read_seq.sv
module test_eeprom_read_seq;
    localparam int PH = 4;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [15:0] rd_offset = 16'h0;
    logic [CW-1:0] rd_count = '0;
    logic busy, done, byte_valid, rom_acc_hi, rom_acc_lo, rom_clk, rom_dout, rom_din;
    logic [7:0] rx_byte;

    always #2.5 clk = ~clk;

    eeprom_read_seq #(.PHASE_CLKS(PH), .COUNT_W(CW)) i_eeprom_read_seq (
        .clk(clk), .rst(rst), .start(start), .rd_offset(rd_offset), .rd_count(rd_count),
        .busy(busy), .done(done), .byte_valid(byte_valid), .rx_byte(rx_byte),
        .rom_acc_hi(rom_acc_hi), .rom_acc_lo(rom_acc_lo), .rom_clk(rom_clk),
        .rom_dout(rom_dout), .rom_din(rom_din)
    );

    int checks = 0;
    int errors = 0;

    function automatic logic [7:0] rom_data(logic [15:0] a);
        return {a[3:0], a[7:4]} ^ a[15:8] ^ 8'h5C;
    endfunction

    // Responder and protocol monitor state
    int rises = 0;
    logic [23:0] hdr = '0;
    int hs_err = 0, gate_err = 0, dout_err = 0, width_err = 0, done_err = 0;
    int opens = 0, done_n = 0, got_n = 0, high_len = 0, cyc = 0;
    int hi_rise_cyc = 0, lo_rise_cyc = 0;
    logic [7:0] got [0:15];
    logic p_hi = 1'b0, p_lo = 1'b1, p_clk = 1'b0, p_dout = 1'b0, p_done = 1'b0;

    always_comb begin
        int j;
        logic [15:0] a;
        j = rises - 25;
        a = hdr[15:0] + 16'(j / 8);
        if (rises >= 25) rom_din = rom_data(a)[7 - (j % 8)];
        else             rom_din = 1'b0;
    end

    always @(negedge clk) begin
        if (!rst) begin
            cyc <= cyc + 1;
            if (rom_acc_hi && !p_hi) begin
                if (!rom_acc_lo || !p_lo) hs_err <= hs_err + 1;
                hi_rise_cyc <= cyc;
            end
            if (!rom_acc_lo && p_lo) begin
                if (!rom_acc_hi || !p_hi || cyc - hi_rise_cyc < PH) hs_err <= hs_err + 1;
                rises <= 0; hdr <= '0; opens <= opens + 1;
            end
            if (rom_acc_lo && !p_lo) begin
                if (!rom_acc_hi || !p_hi) hs_err <= hs_err + 1;
                lo_rise_cyc <= cyc;
            end
            if (!rom_acc_hi && p_hi) begin
                if (!rom_acc_lo || !p_lo || cyc - lo_rise_cyc < PH) hs_err <= hs_err + 1;
            end
            if (rom_clk && !(rom_acc_hi && !rom_acc_lo)) gate_err <= gate_err + 1;
            if (rom_clk && rom_dout != p_dout) dout_err <= dout_err + 1;
            if (rom_clk && !p_clk) begin
                if (rises < 24) hdr <= {hdr[22:0], rom_dout};
                rises <= rises + 1;
                high_len <= 1;
            end else if (rom_clk) begin
                high_len <= high_len + 1;
            end
            if (!rom_clk && p_clk && high_len != PH) width_err <= width_err + 1;
            if (done) done_n <= done_n + 1;
            if (done && p_done) done_err <= done_err + 1;
            if (byte_valid) begin
                if (!busy) done_err <= done_err + 1;
                if (got_n < 16) got[got_n] <= rx_byte;
                got_n <= got_n + 1;
            end
            p_hi <= rom_acc_hi; p_lo <= rom_acc_lo; p_clk <= rom_clk;
            p_dout <= rom_dout; p_done <= done;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        hs_err = 0; gate_err = 0; dout_err = 0; width_err = 0; done_err = 0;
        opens = 0; done_n = 0; got_n = 0;
    endtask

    task automatic pulse_start(input logic [15:0] off, input logic [CW-1:0] n);
        rd_offset = off; rd_count = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int k = 0;
        while (!done && k < 20000) begin @(negedge clk); k++; end
        check(done == 1'b1, "R10", "done seen", done, 1);
    endtask

    task automatic check_run(input logic [15:0] off, input int n);
        check(hs_err == 0, "R2", "open/close ordering errors", hs_err, 0);
        check(opens == 1, "R3", "bus openings", opens, 1);
        check(hdr == {8'h03, off}, "R4", "header bits", hdr, {8'h03, off});
        check(dout_err == 0, "R5", "dout change while clock high", dout_err, 0);
        check(width_err == 0, "R7", "clock high width errors", width_err, 0);
        check(gate_err == 0, "R11", "clock outside access", gate_err, 0);
        check(done_err == 0, "R10", "done/valid pulse errors", done_err, 0);
        check(got_n == n, "R6", "bytes received", got_n, n);
        for (int i = 0; i < n && i < 16; i++)
            check(got[i] == rom_data(off + 16'(i)), "R6", "byte value",
                  got[i], rom_data(off + 16'(i)));
    endtask

    task automatic t_reset();
        check(rom_acc_hi == 0 && rom_acc_lo == 1 && rom_clk == 0 && rom_dout == 0,
              "R1", "bus lines after reset",
              {rom_acc_hi, rom_acc_lo, rom_clk, rom_dout}, 4'b0100);
        check(busy == 0 && done == 0 && byte_valid == 0, "R1", "status after reset",
              {busy, done, byte_valid}, 0);
    endtask

    task automatic t_read(input logic [15:0] off, input int n);
        clear_mon();
        pulse_start(off, CW'(n));
        check(busy == 1'b1, "R9", "busy after start", busy, 1);
        wait_done();
        check(busy == 1'b0, "R9", "busy with done", busy, 0);
        @(negedge clk);
        check_run(off, n);
    endtask

    task automatic t_zero();
        clear_mon();
        pulse_start(16'h0BAD, '0);
        wait_done();
        @(negedge clk);
        check(got_n == 0, "R8", "no bytes for zero count", got_n, 0);
        check(hdr == {8'h03, 16'h0BAD}, "R8", "header for zero count", hdr, {8'h03, 16'h0BAD});
        check(done_n == 1 && opens == 1, "R8", "done and open count", done_n, 1);
    endtask

    task automatic t_ignore();
        clear_mon();
        pulse_start(16'h2468, CW'(2));
        repeat (60) @(negedge clk);
        pulse_start(16'hAAAA, CW'(5));
        wait_done();
        repeat (30) @(negedge clk);
        check(busy == 1'b0, "R9", "no deferred start", busy, 0);
        check(done_n == 1, "R9", "done pulses", done_n, 1);
        check_run(16'h2468, 2);
    endtask

    task automatic t_back_to_back();
        clear_mon();
        pulse_start(16'h0100, CW'(1));
        wait_done();
        clear_mon();
        pulse_start(16'h7F3E, CW'(2));
        check(busy == 1'b1, "R9", "start in done cycle accepted", busy, 1);
        wait_done();
        @(negedge clk);
        check_run(16'h7F3E, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read(16'h1234, 3);
        t_read(16'hFFFE, 2);
        t_zero();
        t_ignore();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule